// File: doc/BRIEF.md
# Sub-Pixel Edge Timing Generator

This block produces the fast readout clocks for an image-sensor analog front end. It runs on a clock 48 times the pixel rate, so each pixel period holds 48 edge positions. A phase counter walks positions 0 to 47 and wraps. The reset-gate clock and the shared horizontal clock pair are high between a programmable rise position and a programmable fall position. Each of them can be inverted. The horizontal clock pair also has complementary partners. Three more settings each place a one-cycle strobe: two correlated-sampling strobes and a latch strobe for output data.

Every position setting is a 6-bit code. The upper two bits select a quadrant of the period and the lower four bits select an offset of 0 to 11 inside that quadrant. Offsets 12 to 15 are illegal. A new setting is captured into a shadow copy when `cfg_we` is high. The shadow copy becomes active only when the period rolls over, so a clock is never cut short or stretched in the middle of a period. A period marker pulses at position 0 so that neighbouring logic can align to the period. All pins here are plain level signals; the block has no streaming data path.

Top module: `subpix_edge_gen`

## Requirements
- R1: The phase counter steps 0,1,…,47 and then returns to 0. `period_start` is high for exactly the one fast cycle whose phase is 0.
- R2: A code selects position quadrant*12 + offset, where quadrant = code[5:4] and offset = code[3:0]. A code with an offset of 12 to 15 matches no position.
- R3: `cfg_err` goes high on a write in which any of the seven position codes has an offset of 12 to 15. After that it stays high until reset.
- R4: Before inversion, `rg` is high from its rise position and goes low at its fall position. When fall is earlier than rise, the high time wraps across position 0. When the two positions are equal, or neither code is legal, the level holds. A legal rise with an illegal fall leaves the level high; the reverse leaves it low.
- R5: When a polarity bit is 1 it inverts its clock (`rg` or `h1`/`h3`). When it is 0 the clock passes through unchanged.
- R6: `h1` and `h3` follow one shared setting. `h2` is always the complement of `h1`, and `h4` is always the complement of `h3`.
- R7: `shp` and `shd` are each high for exactly the one fast cycle whose phase equals their decoded position.
- R8: `dout_latch` is high for exactly the one fast cycle whose phase equals its decoded position.
- R9: A write takes effect from the phase-0 cycle that follows the next 47-to-0 rollover. The rest of the current period keeps the old settings.
- R10: A synchronous reset sets the phase to 0 and clears `cfg_err`. It sets every active code to an illegal value and both polarity bits to 0. As a result `rg`, `h1`, `h3` and all strobes are low, and `h2` and `h4` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, 48 times the pixel rate |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Capture all configuration inputs into the shadow copy |
| cfg_rg_rise | input | 6 | Reset-gate rise position code |
| cfg_rg_fall | input | 6 | Reset-gate fall position code |
| cfg_rg_inv | input | 1 | Reset-gate polarity, 1 inverts |
| cfg_h_rise | input | 6 | Horizontal clock rise position code |
| cfg_h_fall | input | 6 | Horizontal clock fall position code |
| cfg_h_inv | input | 1 | Horizontal clock polarity, 1 inverts |
| cfg_shp_pos | input | 6 | Reset-level sample strobe position code |
| cfg_shd_pos | input | 6 | Data-level sample strobe position code |
| cfg_dout_pos | input | 6 | Output-data latch strobe position code |
| rg | output | 1 | Reset-gate clock |
| h1 | output | 1 | Horizontal clock 1 |
| h2 | output | 1 | Complement of h1 |
| h3 | output | 1 | Horizontal clock 3 (same setting as h1) |
| h4 | output | 1 | Complement of h3 |
| shp | output | 1 | Reset-level sample strobe |
| shd | output | 1 | Data-level sample strobe |
| dout_latch | output | 1 | Output-data latch strobe |
| period_start | output | 1 | Marker pulse at phase 0 |
| cfg_err | output | 1 | Sticky flag for an illegal code write |

## Verification
The hardest case to reach is the held level. It happens when the rise and fall positions are equal, or when both codes are illegal. The output then depends on the level left behind by the previous configuration, so it cannot be set from the ports in a single step. The stimulus chains configurations on purpose. First it loads a wrapping setting that leaves both clocks high at position 47. Then it loads equal positions and expects that high level to persist, with inversion applied. Each write is made just after `period_start`, so the rest of that period also shows that the old strobe positions are still active. A sweep of all 64 strobe codes covers the quadrant decode and the illegal offsets.

// File: rtl/sep_pkg.sv
package sep_pkg;
  localparam int SEP_QUAD_LEN = 12;
  localparam int SEP_NUM_CODES = 7;

  typedef enum int {
    SEL_RG_RISE = 0,
    SEL_RG_FALL = 1,
    SEL_H_RISE  = 2,
    SEL_H_FALL  = 3,
    SEL_SHP     = 4,
    SEL_SHD     = 5,
    SEL_DOUT    = 6
  } code_sel_e;
endpackage

// File: rtl/sep_phase_ctr.sv
module sep_phase_ctr #(
  parameter int PHASES = 48,
  localparam int PH_W = $clog2(PHASES)
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PH_W-1:0] ph,
  output logic            wrap
);
  assign wrap = (ph == PH_W'(PHASES - 1));

  always_ff @(posedge clk) begin
    if (rst || wrap) ph <= '0;
    else             ph <= ph + 1'b1;
  end
endmodule

// File: rtl/sep_code_dec.sv
module sep_code_dec #(
  parameter int QUAD_LEN = 12,
  parameter int OFF_W    = 4,
  parameter int PH_W     = 6
) (
  input  logic [OFF_W+1:0] code,
  output logic [PH_W-1:0]  pos,
  output logic             valid
);
  logic [1:0]       quad;
  logic [OFF_W-1:0] off;

  assign quad  = code[OFF_W+1:OFF_W];
  assign off   = code[OFF_W-1:0];
  assign valid = (off < OFF_W'(QUAD_LEN));
  assign pos   = PH_W'(quad) * PH_W'(QUAD_LEN) + PH_W'(off);
endmodule

// File: rtl/sep_edge_chan.sv
module sep_edge_chan #(
  parameter int PH_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PH_W-1:0] ph,
  input  logic [PH_W-1:0] rise_pos,
  input  logic            rise_ok,
  input  logic [PH_W-1:0] fall_pos,
  input  logic            fall_ok,
  input  logic            inv,
  output logic            out
);
  logic hit_r, hit_f, lvl_q, lvl_d;

  assign hit_r = rise_ok && (ph == rise_pos);
  assign hit_f = fall_ok && (ph == fall_pos);

  always_comb begin
    unique case ({hit_r, hit_f})
      2'b10:   lvl_d = 1'b1;
      2'b01:   lvl_d = 1'b0;
      default: lvl_d = lvl_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl_d;
  end

  assign out = lvl_d ^ inv;
endmodule

// File: rtl/subpix_edge_gen.sv
module subpix_edge_gen
  import sep_pkg::*;
#(
  parameter int QUAD_LEN = SEP_QUAD_LEN,
  localparam int PHASES = 4 * QUAD_LEN,
  localparam int PH_W   = $clog2(PHASES),
  localparam int OFF_W  = $clog2(QUAD_LEN),
  localparam int CODE_W = OFF_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CODE_W-1:0] cfg_rg_rise,
  input  logic [CODE_W-1:0] cfg_rg_fall,
  input  logic              cfg_rg_inv,
  input  logic [CODE_W-1:0] cfg_h_rise,
  input  logic [CODE_W-1:0] cfg_h_fall,
  input  logic              cfg_h_inv,
  input  logic [CODE_W-1:0] cfg_shp_pos,
  input  logic [CODE_W-1:0] cfg_shd_pos,
  input  logic [CODE_W-1:0] cfg_dout_pos,
  output logic              rg,
  output logic              h1,
  output logic              h2,
  output logic              h3,
  output logic              h4,
  output logic              shp,
  output logic              shd,
  output logic              dout_latch,
  output logic              period_start,
  output logic              cfg_err
);
  localparam int NCODE = SEP_NUM_CODES;
  // Offset field all ones is illegal whenever QUAD_LEN is not a power of two.
  localparam logic [CODE_W-1:0] IDLE_CODE = CODE_W'((1 << OFF_W) - 1);

  logic [PH_W-1:0]   ph;
  logic              wrap;
  logic [CODE_W-1:0] wr_code  [NCODE];
  logic [CODE_W-1:0] sh_code  [NCODE];
  logic [CODE_W-1:0] act_code [NCODE];
  logic [PH_W-1:0]   act_pos  [NCODE];
  logic              act_ok   [NCODE];
  logic              sh_rg_inv, sh_h_inv, act_rg_inv, act_h_inv;
  logic              wr_bad;
  logic              h_lvl;

  assign wr_code[SEL_RG_RISE] = cfg_rg_rise;
  assign wr_code[SEL_RG_FALL] = cfg_rg_fall;
  assign wr_code[SEL_H_RISE]  = cfg_h_rise;
  assign wr_code[SEL_H_FALL]  = cfg_h_fall;
  assign wr_code[SEL_SHP]     = cfg_shp_pos;
  assign wr_code[SEL_SHD]     = cfg_shd_pos;
  assign wr_code[SEL_DOUT]    = cfg_dout_pos;

  sep_phase_ctr #(.PHASES(PHASES)) u_ctr (
    .clk (clk),
    .rst (rst),
    .ph  (ph),
    .wrap(wrap)
  );

  // Shadow capture on write, transfer to active set only at period rollover.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCODE; i++) begin
        sh_code[i]  <= IDLE_CODE;
        act_code[i] <= IDLE_CODE;
      end
      sh_rg_inv  <= 1'b0;
      sh_h_inv   <= 1'b0;
      act_rg_inv <= 1'b0;
      act_h_inv  <= 1'b0;
    end else begin
      if (cfg_we) begin
        for (int i = 0; i < NCODE; i++) sh_code[i] <= wr_code[i];
        sh_rg_inv <= cfg_rg_inv;
        sh_h_inv  <= cfg_h_inv;
      end
      if (wrap) begin
        for (int i = 0; i < NCODE; i++) act_code[i] <= sh_code[i];
        act_rg_inv <= sh_rg_inv;
        act_h_inv  <= sh_h_inv;
      end
    end
  end

  always_comb begin
    wr_bad = 1'b0;
    for (int i = 0; i < NCODE; i++)
      if (wr_code[i][OFF_W-1:0] >= OFF_W'(QUAD_LEN)) wr_bad = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                   cfg_err <= 1'b0;
    else if (cfg_we && wr_bad) cfg_err <= 1'b1;
  end

  for (genvar g = 0; g < NCODE; g++) begin : g_dec
    sep_code_dec #(.QUAD_LEN(QUAD_LEN), .OFF_W(OFF_W), .PH_W(PH_W)) u_dec (
      .code (act_code[g]),
      .pos  (act_pos[g]),
      .valid(act_ok[g])
    );
  end

  sep_edge_chan #(.PH_W(PH_W)) u_rg (
    .clk     (clk),
    .rst     (rst),
    .ph      (ph),
    .rise_pos(act_pos[SEL_RG_RISE]),
    .rise_ok (act_ok[SEL_RG_RISE]),
    .fall_pos(act_pos[SEL_RG_FALL]),
    .fall_ok (act_ok[SEL_RG_FALL]),
    .inv     (act_rg_inv),
    .out     (rg)
  );

  sep_edge_chan #(.PH_W(PH_W)) u_h (
    .clk     (clk),
    .rst     (rst),
    .ph      (ph),
    .rise_pos(act_pos[SEL_H_RISE]),
    .rise_ok (act_ok[SEL_H_RISE]),
    .fall_pos(act_pos[SEL_H_FALL]),
    .fall_ok (act_ok[SEL_H_FALL]),
    .inv     (act_h_inv),
    .out     (h_lvl)
  );

  assign h1 = h_lvl;
  assign h3 = h_lvl;
  assign h2 = ~h1;
  assign h4 = ~h3;

  assign shp          = act_ok[SEL_SHP]  && (ph == act_pos[SEL_SHP]);
  assign shd          = act_ok[SEL_SHD]  && (ph == act_pos[SEL_SHD]);
  assign dout_latch   = act_ok[SEL_DOUT] && (ph == act_pos[SEL_DOUT]);
  assign period_start = (ph == '0);
endmodule

// File: rtl/sep_chk.sv
module sep_chk #(
  parameter int PH_W   = 6,
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [PH_W-1:0]   ph,
  input logic              wrap,
  input logic              period_start,
  input logic              shp,
  input logic              shd,
  input logic              dout_latch,
  input logic              cfg_err,
  input logic [CODE_W-1:0] act_shp
);
  p_ph_step_r1: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> (ph == $past(ph) + 1'b1));
  p_ph_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (ph == '0) && period_start);
  p_marker_once_r1: assert property (@(posedge clk) disable iff (rst)
    period_start |=> !period_start);
  p_err_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err);
  p_shp_single_r7: assert property (@(posedge clk) disable iff (rst)
    shp |=> !shp);
  p_shd_single_r7: assert property (@(posedge clk) disable iff (rst)
    shd |=> !shd);
  p_dout_single_r8: assert property (@(posedge clk) disable iff (rst)
    dout_latch |=> !dout_latch);
  p_active_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(act_shp));
endmodule

bind subpix_edge_gen sep_chk #(.PH_W(PH_W), .CODE_W(CODE_W)) u_sep_chk (
  .clk         (clk),
  .rst         (rst),
  .ph          (ph),
  .wrap        (wrap),
  .period_start(period_start),
  .shp         (shp),
  .shd         (shd),
  .dout_latch  (dout_latch),
  .cfg_err     (cfg_err),
  .act_shp     (act_code[4])
);

// File: tb/tb_subpix_edge_gen.sv
module tb_subpix_edge_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [5:0] cfg_rg_rise = '0, cfg_rg_fall = '0, cfg_h_rise = '0, cfg_h_fall = '0;
  logic [5:0] cfg_shp_pos = '0, cfg_shd_pos = '0, cfg_dout_pos = '0;
  logic cfg_rg_inv = 1'b0, cfg_h_inv = 1'b0;
  logic rg, h1, h2, h3, h4, shp, shd, dout_latch, period_start, cfg_err;

  int vectors = 0;
  int miscompares = 0;

  // Bench copy of the active configuration and the levels held between configs.
  logic [5:0] rr, rf, hr, hf, sp, sd, dp;
  logic ri, hi, rg_hold, h_hold;

  always #4 clk = ~clk;

  subpix_edge_gen dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we),
    .cfg_rg_rise(cfg_rg_rise), .cfg_rg_fall(cfg_rg_fall), .cfg_rg_inv(cfg_rg_inv),
    .cfg_h_rise(cfg_h_rise), .cfg_h_fall(cfg_h_fall), .cfg_h_inv(cfg_h_inv),
    .cfg_shp_pos(cfg_shp_pos), .cfg_shd_pos(cfg_shd_pos), .cfg_dout_pos(cfg_dout_pos),
    .rg(rg), .h1(h1), .h2(h2), .h3(h3), .h4(h4), .shp(shp), .shd(shd),
    .dout_latch(dout_latch), .period_start(period_start), .cfg_err(cfg_err)
  );

  task automatic chk(input logic got, input logic exp, input string tag);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  // R2: position = code[5:4]*12 + code[3:0]; offsets 12..15 give no position.
  function automatic int pos_of(logic [5:0] c);
    if (c[3:0] < 4'd12) return int'(c[5:4]) * 12 + int'(c[3:0]);
    return -1;
  endfunction

  // R4: steady-state level before polarity.
  function automatic logic lvl(logic [5:0] r, logic [5:0] f, int p, logic held);
    int pr = pos_of(r);
    int pf = pos_of(f);
    if (pr >= 0 && pf >= 0 && pr != pf) begin
      if (pr < pf) return (p >= pr) && (p < pf);
      return (p >= pr) || (p < pf);
    end
    if (pr >= 0 && pf < 0) return 1'b1;
    if (pf >= 0 && pr < 0) return 1'b0;
    return held;
  endfunction

  task automatic chk_strobes(input int p, input logic [5:0] a, input logic [5:0] b,
                             input logic [5:0] c, input string tag);
    chk(shp, pos_of(a) == p, {tag, " R2 R7 shp"});
    chk(shd, pos_of(b) == p, {tag, " R2 R7 shd"});
    chk(dout_latch, pos_of(c) == p, {tag, " R8 dout_latch"});
  endtask

  task automatic check_period();
    for (int p = 0; p < 48; p++) begin
      logic e_rg, e_h;
      e_rg = lvl(rr, rf, p, rg_hold) ^ ri;
      e_h  = lvl(hr, hf, p, h_hold) ^ hi;
      chk(rg, e_rg, "R4 R5 rg");
      chk(h1, e_h, "R5 R6 h1");
      chk(h3, e_h, "R6 h3");
      chk(h2, ~e_h, "R6 h2");
      chk(h4, ~e_h, "R6 h4");
      chk(period_start, p == 0, "R1 period_start");
      chk_strobes(p, sp, sd, dp, "steady");
      @(negedge clk);
    end
    rg_hold = lvl(rr, rf, 47, rg_hold);
    h_hold  = lvl(hr, hf, 47, h_hold);
  endtask

  task automatic load(input logic [5:0] n_rr, input logic [5:0] n_rf, input logic n_ri,
                      input logic [5:0] n_hr, input logic [5:0] n_hf, input logic n_hi,
                      input logic [5:0] n_sp, input logic [5:0] n_sd, input logic [5:0] n_dp);
    while (!period_start) @(negedge clk);
    cfg_rg_rise = n_rr; cfg_rg_fall = n_rf; cfg_rg_inv = n_ri;
    cfg_h_rise = n_hr;  cfg_h_fall = n_hf;  cfg_h_inv = n_hi;
    cfg_shp_pos = n_sp; cfg_shd_pos = n_sd; cfg_dout_pos = n_dp;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    // R9: remainder of the write period still runs on the old settings.
    for (int p = 1; p < 48; p++) begin
      chk_strobes(p, sp, sd, dp, "R9 old");
      @(negedge clk);
    end
    rr = n_rr; rf = n_rf; ri = n_ri; hr = n_hr; hf = n_hf; hi = n_hi;
    sp = n_sp; sd = n_sd; dp = n_dp;
    repeat (48) @(negedge clk);
    check_period();
  endtask

  task automatic check_reset_state();
    chk(rg, 1'b0, "R10 rg");
    chk(h1, 1'b0, "R10 h1");
    chk(h3, 1'b0, "R10 h3");
    chk(h2, 1'b1, "R10 h2");
    chk(h4, 1'b1, "R10 h4");
    chk(shp, 1'b0, "R10 shp");
    chk(shd, 1'b0, "R10 shd");
    chk(dout_latch, 1'b0, "R10 dout_latch");
    chk(cfg_err, 1'b0, "R10 cfg_err");
    chk(period_start, 1'b1, "R10 R1 phase zero");
  endtask

  task automatic set_defaults();
    rr = 6'h0F; rf = 6'h0F; hr = 6'h0F; hf = 6'h0F;
    sp = 6'h0F; sd = 6'h0F; dp = 6'h0F;
    ri = 1'b0; hi = 1'b0; rg_hold = 1'b0; h_hold = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    set_defaults();
    repeat (3) @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    @(negedge clk);

    // C1: plain windows in several quadrants.
    load(6'h05, 6'h18, 1'b0, 6'h26, 6'h38, 1'b0, 6'h0B, 6'h30, 6'h2B);
    chk(cfg_err, 1'b0, "R3 no error after legal write");
    // C2: windows that wrap across position 0, RG inverted.
    load(6'h34, 6'h03, 1'b1, 6'h3B, 6'h00, 1'b0, 6'h00, 6'h3B, 6'h10);
    chk(cfg_err, 1'b0, "R3 no error after legal write");
    // C3: equal edges hold the prior level; illegal strobe codes never fire.
    load(6'h15, 6'h15, 1'b0, 6'h22, 6'h22, 1'b1, 6'h0C, 6'h2F, 6'h1D);
    chk(cfg_err, 1'b1, "R3 error set by illegal offset");
    // C4: one illegal edge code per clock.
    load(6'h0E, 6'h09, 1'b1, 6'h07, 6'h3F, 1'b0, 6'h2A, 6'h01, 6'h1B);
    chk(cfg_err, 1'b1, "R3 error sticky");

    // Sweep every strobe code through each strobe field.
    for (int c = 0; c < 64; c++)
      load(6'h0E, 6'h09, 1'b1, 6'h07, 6'h3F, 1'b0,
           6'(c), 6'(63 - c), 6'(c) ^ 6'h15);
    chk(cfg_err, 1'b1, "R3 error still set after sweep");

    // Mid-run reset.
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    set_defaults();
    while (!period_start) @(negedge clk);
    check_period();
    chk(cfg_err, 1'b0, "R10 cfg_err stays clear");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule